// File: doc/BRIEF.md
# Magic Packet Wake-Up Detector

This block watches a received Ethernet frame as a byte stream. Each byte comes with a valid strobe. The first byte of a frame carries a start marker and the last byte carries an end marker. The first six bytes of the frame are the destination address, and the block keeps them in a small register file. Every byte after them goes to a sequence matcher. The matcher looks for a wake-up pattern: six 0xFF bytes followed at once by sixteen back-to-back copies of the captured address. Any other bytes may come before or after the pattern. The address used is always the one the frame itself carries; no station address is programmed.

The decision is taken on the last byte of the frame. A wake-up happens only when the MAC reports the frame as good and the external address filter passes it. When the magic enable is set and the pattern was seen, both the general wake status and the magic-specific status are raised. When the filter-wake enable is set, any good frame that passes the filter raises the general wake status, with or without the pattern. Both status bits are sticky. Software clears them by writing ones to a clear port. When a set and a clear fall in the same cycle, the set wins.

Top module: `wol_magic_det`

## Requirements
- R1: After reset, `wake_sts` and `magic_sts` are both 0.
- R2: The compare address is the frame's first six valid bytes, with the byte carrying `rx_sof` taken as address byte 0. A pattern built from any other address does not wake.
- R3: With `magic_en`=1, `frame_good`=1 and `filt_pass`=1, a payload holding six 0xFF bytes followed by sixteen consecutive copies of the address sets both status bits. Other bytes may come before and after the pattern. The bits are 1 in the cycle after the end-of-frame beat.
- R4: A pattern with only fifteen address copies, or with a wrong byte inside a copy, does not wake when `filt_wake_en`=0.
- R5: A run of more than six 0xFF bytes still leads into the address copies. A 0xFF byte that breaks an address copy counts as the first byte of a new 0xFF run.
- R6: With `filt_pass`=0 on the end-of-frame beat, no status bit is set.
- R7: With `frame_good`=0 on the end-of-frame beat, no status bit is set. A frame cut off by a new `rx_sof` before its end is dropped, and only the frame that follows is judged.
- R8: With `magic_en`=0, a magic packet does not set `magic_sts`.
- R9: With `filt_wake_en`=1, any good frame that passes the filter sets `wake_sts` but not `magic_sts`.
- R10: A cycle with `clr_we`=1 clears `wake_sts` when `clr_wdata[0]`=1 and clears `magic_sts` when `clr_wdata[1]`=1. A bit written as 0 leaves its status unchanged.
- R11: If a set and a clear of the same status bit fall in the same cycle, the bit ends up 1.
- R12: Cycles with `rx_valid`=0 are ignored, whatever `rx_data` carries, and do not break a pattern in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Received byte |
| frame_good | input | 1 | MAC reports the frame as good; sampled on the end-of-frame beat |
| filt_pass | input | 1 | External address filter accepted the frame; sampled on the end-of-frame beat |
| magic_en | input | 1 | Enables wake on the magic pattern |
| filt_wake_en | input | 1 | Enables wake on any frame that passes the filter |
| clr_we | input | 1 | Write strobe for the clear port |
| clr_wdata | input | 2 | Write-one-to-clear: bit 0 clears wake status, bit 1 clears magic status |
| wake_sts | output | 1 | Sticky general wake-up interrupt status |
| magic_sts | output | 1 | Sticky magic-packet wake status |

## Verification
The bench builds the block with its default sizes: a six-byte address, a six-byte 0xFF preamble and sixteen repeats. It therefore sends full-length 102-byte patterns, and it also sends a pattern one copy short. Those sizes bring within reach the restart cases: an over-long 0xFF run, a copy broken by 0xFF, and frames cut off by a new start. They also cover a clear landing on the same cycle as an end-of-frame set. The addresses the bench uses contain no 0xFF byte. Under that condition the bench can check the matcher against a plain substring search over the payload.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic {PH_SYNC, PH_ADDR} mp_phase_e;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam int CLR_WAKE_BIT  = 0;
  localparam int CLR_MAGIC_BIT = 1;
  localparam int CLR_W         = 2;
endpackage

// File: rtl/mp_frame_front.sv
module mp_frame_front #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  output logic [ADDR_BYTES*8-1:0] addr_flat,
  output logic                    restart,
  output logic                    payload_step,
  output logic                    eof_beat
);
  localparam int IW = $clog2(ADDR_BYTES + 1);

  logic          in_frame_q;
  logic [IW-1:0] idx_q;
  logic [7:0]    addr_q [ADDR_BYTES];
  logic          beat, addr_we;
  logic [IW-1:0] addr_idx;

  assign beat         = rx_valid & (rx_sof | in_frame_q);
  assign restart      = beat & rx_sof;
  assign eof_beat     = beat & rx_eof;
  assign payload_step = beat & ~rx_sof & (idx_q == IW'(ADDR_BYTES));
  assign addr_we      = restart | (beat & (idx_q < IW'(ADDR_BYTES)));
  assign addr_idx     = rx_sof ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
    end else begin
      if (rx_valid & rx_sof & ~rx_eof) in_frame_q <= 1'b1;
      else if (eof_beat)               in_frame_q <= 1'b0;
      if (restart)                     idx_q <= IW'(1);
      else if (beat && idx_q < IW'(ADDR_BYTES)) idx_q <= idx_q + IW'(1);
    end
  end

  // address file: plain write port, no reset
  always_ff @(posedge clk) begin
    if (addr_we) addr_q[addr_idx] <= rx_data;
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_flat
    assign addr_flat[g*8 +: 8] = addr_q[g];
  end
endmodule

// File: rtl/mp_seq_match.sv
module mp_seq_match
  import mp_pkg::*;
#(
  parameter int SYNC_BYTES = 6,
  parameter int ADDR_BYTES = 6,
  parameter int REPEATS    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    restart,
  input  logic                    step,
  input  logic [7:0]              rx_byte,
  input  logic [ADDR_BYTES*8-1:0] addr_flat,
  output logic                    found_q,
  output logic                    found_now
);
  localparam int SW = $clog2(SYNC_BYTES + 1);
  localparam int PW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;

  mp_phase_e     phase_q, phase_n;
  logic [SW-1:0] sync_q, sync_n;
  logic [PW-1:0] pos_q, pos_n, p;
  logic [RW-1:0] rep_q, rep_n, r;
  logic          take_addr;

  always_comb begin
    phase_n   = phase_q;
    sync_n    = sync_q;
    pos_n     = pos_q;
    rep_n     = rep_q;
    found_now = 1'b0;
    take_addr = 1'b0;
    p         = pos_q;
    r         = rep_q;
    if (step) begin
      if (phase_q == PH_ADDR) begin
        take_addr = 1'b1;
      end else if (sync_q == SW'(SYNC_BYTES) && rx_byte != SYNC_BYTE) begin
        take_addr = 1'b1;
        p = '0;
        r = '0;
      end else if (rx_byte == SYNC_BYTE) begin
        if (sync_q != SW'(SYNC_BYTES)) sync_n = sync_q + SW'(1);
      end else begin
        sync_n = '0;
      end
      if (take_addr) begin
        if (rx_byte == addr_flat[int'(p)*8 +: 8]) begin
          phase_n = PH_ADDR;
          if (p == PW'(ADDR_BYTES - 1)) begin
            pos_n = '0;
            if (r == RW'(REPEATS - 1)) begin
              found_now = 1'b1;
              phase_n   = PH_SYNC;
              sync_n    = '0;
              rep_n     = '0;
            end else begin
              rep_n = r + RW'(1);
            end
          end else begin
            pos_n = p + PW'(1);
            rep_n = r;
          end
        end else begin
          phase_n = PH_SYNC;
          sync_n  = (rx_byte == SYNC_BYTE) ? SW'(1) : '0;
          pos_n   = '0;
          rep_n   = '0;
        end
      end
    end
    if (restart) begin
      phase_n   = PH_SYNC;
      sync_n    = '0;
      pos_n     = '0;
      rep_n     = '0;
      found_now = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SYNC;
      sync_q  <= '0;
      pos_q   <= '0;
      rep_q   <= '0;
      found_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      sync_q  <= sync_n;
      pos_q   <= pos_n;
      rep_q   <= rep_n;
      found_q <= restart ? 1'b0 : (found_q | found_now);
    end
  end
endmodule

// File: rtl/mp_wake_status.sv
module mp_wake_status
  import mp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_wake,
  input  logic             set_magic,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_wdata,
  output logic             wake_sts,
  output logic             magic_sts
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_sts  <= 1'b0;
      magic_sts <= 1'b0;
    end else begin
      if (set_wake)                           wake_sts <= 1'b1;
      else if (clr_we && clr_wdata[CLR_WAKE_BIT]) wake_sts <= 1'b0;
      if (set_magic)                           magic_sts <= 1'b1;
      else if (clr_we && clr_wdata[CLR_MAGIC_BIT]) magic_sts <= 1'b0;
    end
  end
endmodule

// File: rtl/wol_magic_det.sv
module wol_magic_det
  import mp_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_BYTES = 6,
  parameter int REPEATS    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  input  logic             frame_good,
  input  logic             filt_pass,
  input  logic             magic_en,
  input  logic             filt_wake_en,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_wdata,
  output logic             wake_sts,
  output logic             magic_sts
);
  logic [ADDR_BYTES*8-1:0] addr_flat;
  logic restart, payload_step, eof_beat;
  logic found_q, found_now;
  logic frame_ok, magic_hit, set_wake;

  mp_frame_front #(.ADDR_BYTES(ADDR_BYTES)) u_front (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .addr_flat(addr_flat),
    .restart(restart), .payload_step(payload_step), .eof_beat(eof_beat)
  );

  mp_seq_match #(.SYNC_BYTES(SYNC_BYTES), .ADDR_BYTES(ADDR_BYTES),
                 .REPEATS(REPEATS)) u_match (
    .clk(clk), .rst(rst), .restart(restart), .step(payload_step),
    .rx_byte(rx_data), .addr_flat(addr_flat),
    .found_q(found_q), .found_now(found_now)
  );

  assign frame_ok  = eof_beat & frame_good & filt_pass;
  assign magic_hit = frame_ok & magic_en & ~rx_sof & (found_q | found_now);
  assign set_wake  = magic_hit | (frame_ok & filt_wake_en);

  mp_wake_status u_status (
    .clk(clk), .rst(rst), .set_wake(set_wake), .set_magic(magic_hit),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .wake_sts(wake_sts), .magic_sts(magic_sts)
  );
endmodule

// File: rtl/wol_magic_det_chk.sv
module wol_magic_det_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic       rx_eof,
  input logic       frame_good,
  input logic       filt_pass,
  input logic       magic_en,
  input logic       clr_we,
  input logic [1:0] clr_wdata,
  input logic       set_wake,
  input logic       wake_sts,
  input logic       magic_sts
);
  AST_WAKE_NEEDS_GOOD_PASS: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_sts) |-> $past(rx_valid && rx_eof && frame_good && filt_pass)); // R6
  AST_MAGIC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(magic_sts) |-> $past(magic_en)); // R8
  AST_MAGIC_WITH_WAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(magic_sts) |-> wake_sts); // R3
  AST_MAGIC_STICKY: assert property (@(posedge clk) disable iff (rst)
    magic_sts && !(clr_we && clr_wdata[1]) |=> magic_sts); // R10
  AST_MAGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_we && clr_wdata[1] && !(rx_valid && rx_eof) |=> !magic_sts); // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    set_wake |=> wake_sts); // R11
endmodule

bind wol_magic_det wol_magic_det_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .frame_good(frame_good), .filt_pass(filt_pass), .magic_en(magic_en),
  .clr_we(clr_we), .clr_wdata(clr_wdata), .set_wake(set_wake),
  .wake_sts(wake_sts), .magic_sts(magic_sts)
);

// File: tb/sim_wol_magic_det.sv
`timescale 1ns/1ps
module sim_wol_magic_det;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 8'h00;
  logic frame_good = 0, filt_pass = 0, magic_en = 0, filt_wake_en = 0;
  logic clr_we = 0;
  logic [1:0] clr_wdata = 2'b00;
  logic wake_sts, magic_sts;

  always #10 clk = ~clk;

  wol_magic_det u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .frame_good(frame_good),
    .filt_pass(filt_pass), .magic_en(magic_en), .filt_wake_en(filt_wake_en),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .wake_sts(wake_sts), .magic_sts(magic_sts)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  localparam logic [47:0] A1 = 48'h0A1B2C3D4E5F;
  localparam logic [47:0] A2 = 48'h112233445566;
  localparam logic [47:0] A3 = 48'h020304050607;

  task automatic check(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  bit in_fr = 0;
  logic ew = 0, em = 0;

  function automatic bit has_magic(input logic [7:0] f[$]);
    for (int s = 6; s + 102 <= f.size(); s++) begin
      bit ok = 1;
      for (int k = 0; k < 6; k++) if (f[s+k] != 8'hFF) ok = 0;
      for (int k = 0; k < 96; k++) if (f[s+6+k] != f[k%6]) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ew = 0; em = 0; in_fr = 0; mq.delete();
    end else begin
      bit sw, sm, ok, h;
      sw = 0; sm = 0;
      if (rx_valid) begin
        if (rx_sof) begin mq.delete(); in_fr = 1; end
        if (in_fr) begin
          mq.push_back(rx_data);
          if (rx_eof) begin
            ok = frame_good && filt_pass;
            h  = magic_en && ok && has_magic(mq);
            sw = h || (filt_wake_en && ok);
            sm = h;
            in_fr = 0;
          end
        end
      end
      ew = sw ? 1'b1 : ((clr_we && clr_wdata[0]) ? 1'b0 : ew);
      em = sm ? 1'b1 : ((clr_we && clr_wdata[1]) ? 1'b0 : em);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, wake_sts, ew, "model wake_sts");
      check(cur_req, magic_sts, em, "model magic_sts");
    end
  end

  // ---------------- frame building ----------------
  logic [7:0] fq[$];

  task automatic push_addr(input logic [47:0] a, input int n);
    for (int c = 0; c < n; c++)
      for (int b = 5; b >= 0; b--) fq.push_back(a[b*8 +: 8]);
  endtask
  task automatic push_ff(input int n);
    for (int i = 0; i < n; i++) fq.push_back(8'hFF);
  endtask
  task automatic push_misc(input int n);
    for (int i = 0; i < n; i++) fq.push_back(8'h10 + 8'(i));
  endtask

  // sends fq; eof on the last byte unless cut; optional gaps and clear on eof beat
  task automatic send_frame(input bit good, input bit pass, input bit gap,
                            input bit cut, input logic [1:0] clr_eof);
    frame_good = good; filt_pass = pass;
    for (int i = 0; i < fq.size(); i++) begin
      rx_valid = 1; rx_data = fq[i];
      rx_sof = (i == 0);
      rx_eof = !cut && (i == fq.size() - 1);
      if (rx_eof && clr_eof != 2'b00) begin clr_we = 1; clr_wdata = clr_eof; end
      @(negedge clk);
      clr_we = 0; clr_wdata = 2'b00;
      if (gap) begin
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 8'hFF;
        @(negedge clk);
        rx_data = 8'h0A;
        @(negedge clk);
      end
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    fq.delete();
  endtask

  task automatic do_clear(input logic [1:0] bits);
    clr_we = 1; clr_wdata = bits;
    @(negedge clk);
    clr_we = 0; clr_wdata = 2'b00;
  endtask

  task automatic magic_frame(input logic [47:0] da, input logic [47:0] pat, input int copies);
    push_addr(da, 1); push_misc(5); push_ff(6); push_addr(pat, copies); push_misc(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", wake_sts, 1'b0, "wake_sts in reset");
    check("R1", magic_sts, 1'b0, "magic_sts in reset");
    rst = 0;
    @(negedge clk);
    check("R1", wake_sts, 1'b0, "wake_sts after reset");

    magic_en = 1;
    cur_req = "R3";
    magic_frame(A1, A1, 16); send_frame(1, 1, 0, 0, 2'b00);
    check("R3", wake_sts, 1'b1, "full pattern wake");
    check("R3", magic_sts, 1'b1, "full pattern magic");
    do_clear(2'b11);
    check("R10", wake_sts, 1'b0, "clear both wake");
    check("R10", magic_sts, 1'b0, "clear both magic");

    cur_req = "R4";
    magic_frame(A1, A1, 15); send_frame(1, 1, 0, 0, 2'b00);
    check("R4", wake_sts, 1'b0, "fifteen copies");
    push_addr(A1, 1); push_ff(6); push_addr(A1, 7); fq.push_back(8'h55); push_addr(A1, 8);
    send_frame(1, 1, 0, 0, 2'b00);
    check("R4", magic_sts, 1'b0, "broken copy");

    cur_req = "R2";
    magic_frame(A1, A2, 16); send_frame(1, 1, 0, 0, 2'b00);
    check("R2", magic_sts, 1'b0, "pattern of foreign address");
    magic_frame(A2, A2, 16); send_frame(1, 1, 0, 0, 2'b00);
    check("R2", magic_sts, 1'b1, "pattern of own address A2");
    do_clear(2'b11);

    cur_req = "R5";
    push_addr(A3, 1); push_ff(9); push_addr(A3, 16); send_frame(1, 1, 0, 0, 2'b00);
    check("R5", magic_sts, 1'b1, "long FF run");
    do_clear(2'b11);
    push_addr(A3, 1); push_ff(6); fq.push_back(8'h02); fq.push_back(8'h03);
    push_ff(6); push_addr(A3, 16); push_misc(2);
    send_frame(1, 1, 0, 0, 2'b00);
    check("R5", magic_sts, 1'b1, "FF breaks copy then resync");
    do_clear(2'b11);

    cur_req = "R6";
    magic_frame(A1, A1, 16); send_frame(1, 0, 0, 0, 2'b00);
    check("R6", wake_sts, 1'b0, "filter fail");

    cur_req = "R7";
    magic_frame(A1, A1, 16); send_frame(0, 1, 0, 0, 2'b00);
    check("R7", wake_sts, 1'b0, "bad frame");
    magic_frame(A1, A1, 16); send_frame(1, 1, 0, 1, 2'b00);
    push_addr(A1, 1); push_misc(20); send_frame(1, 1, 0, 0, 2'b00);
    check("R7", wake_sts, 1'b0, "aborted frame then plain frame");

    cur_req = "R8";
    magic_en = 0;
    magic_frame(A1, A1, 16); send_frame(1, 1, 0, 0, 2'b00);
    check("R8", magic_sts, 1'b0, "magic disabled");

    cur_req = "R9";
    filt_wake_en = 1;
    push_addr(A2, 1); push_misc(10); send_frame(1, 1, 0, 0, 2'b00);
    check("R9", wake_sts, 1'b1, "filter wake");
    check("R9", magic_sts, 1'b0, "filter wake no magic");
    do_clear(2'b01);
    push_addr(A2, 1); push_misc(10); send_frame(1, 0, 0, 0, 2'b00);
    check("R9", wake_sts, 1'b0, "filter wake needs pass");
    filt_wake_en = 0;

    cur_req = "R10";
    magic_en = 1;
    magic_frame(A3, A3, 16); send_frame(1, 1, 0, 0, 2'b00);
    do_clear(2'b00);
    check("R10", wake_sts, 1'b1, "zero write keeps wake");
    check("R10", magic_sts, 1'b1, "zero write keeps magic");
    do_clear(2'b10);
    check("R10", magic_sts, 1'b0, "bit1 clears magic");
    check("R10", wake_sts, 1'b1, "bit1 leaves wake");
    do_clear(2'b01);
    check("R10", wake_sts, 1'b0, "bit0 clears wake");

    cur_req = "R11";
    magic_frame(A1, A1, 16); send_frame(1, 1, 0, 0, 2'b11);
    check("R11", wake_sts, 1'b1, "set beats clear wake");
    check("R11", magic_sts, 1'b1, "set beats clear magic");
    do_clear(2'b11);

    cur_req = "R12";
    magic_frame(A2, A2, 16); send_frame(1, 1, 1, 0, 2'b00);
    check("R12", magic_sts, 1'b1, "gaps ignored");
    do_clear(2'b11);
    check("R12", wake_sts, 1'b0, "cleared after gap test");

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule